// File: doc/BRIEF.md
# Pixel block border position tracker

This block follows the horizontal position of each incoming luma sample against a grid of fixed-size pixel blocks and marks every sample as lying either in a border zone around a block boundary or inside a block. A downstream coring stage uses the mark to pick between its border gain and its interior gain. One pixel spans two valid sample clocks, so the position inside a block moves on once every second valid clock.

The block size is 8 or 16 pixels and the border zone is 2 or 4 pixels wide. The zone is split evenly across each boundary: the last half-width pixels of a block and the first half-width pixels of the next are marked. A strobe at the start of each active line restarts the count. A 0 to 15 pixel offset sets the position where the line starts, reduced modulo the block size. This moves the grid against the data, so the gain positions stay put when the input timing drifts. The mark is registered and leaves together with a delayed copy of the sample and its valid.

Top module: `pix_blk_border`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `vld_o`, `border_o` and `data_o` are all 0.
- R2: Every pixel occupies two valid clocks. The in-block position advances by one pixel after the second valid clock of a pixel. Clocks with `smp_vld` low and `line_start` low change neither the position nor the pixel phase.
- R3: `blk_large`=1 gives 16-pixel blocks and `blk_large`=0 gives 8-pixel blocks. After the last pixel of a block (position size-1) the position wraps to 0.
- R4: `bdr_wide`=1 marks positions 0, 1, size-2 and size-1 as border. `bdr_wide`=0 marks only positions 0 and size-1. All other positions are interior.
- R5: A clock with `line_start`=1 sets the pixel phase to the first half of a pixel and the position to `grid_ofs` modulo the block size. If `smp_vld` is also high in that clock, that sample is the first half of the pixel at that position. Otherwise the next valid sample is.
- R6: The sample presented in one clock appears on `data_o` in the next clock, with `vld_o` equal to its `smp_vld` and `border_o` equal to its border mark (1 = border). `border_o` is 0 whenever `vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Start of active line strobe |
| smp_vld | input | 1 | Luma sample valid this clock |
| smp_data | input | DW | Luma sample |
| blk_large | input | 1 | 1 = 16-pixel blocks, 0 = 8-pixel blocks |
| bdr_wide | input | 1 | 1 = 4-pixel border zone, 0 = 2-pixel border zone |
| grid_ofs | input | OFS_W | Starting position of the line within the block, in pixels |
| vld_o | output | 1 | Delayed sample valid |
| data_o | output | DW | Delayed luma sample |
| border_o | output | 1 | 1 = delayed sample lies in a border zone |

## Verification
The assertions assume that `smp_vld` and `line_start` are low while reset is held. They also assume that the size, width and offset controls change only at a line start, since the start-of-line check compares the loaded position with the controls of that same clock. The stimulus applies new control settings only in the clock that carries the strobe and holds them for the whole line. It keeps the valid and strobe inputs at 0 during reset.

// File: rtl/pix_blk_border.sv
module pix_blk_border #(
  parameter int DW    = 8,
  parameter int BLK_S = 8,
  parameter int BLK_L = 16,
  parameter int BDR_N = 2,
  parameter int BDR_W = 4,
  parameter int OFS_W = 4,
  localparam int PW   = $clog2(BLK_L + 1),
  localparam int CW   = ((PW > OFS_W) ? PW : OFS_W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  input  logic          blk_large,
  input  logic          bdr_wide,
  input  logic [OFS_W-1:0] grid_ofs,
  output logic          vld_o,
  output logic [DW-1:0] data_o,
  output logic          border_o
);

  logic [CW-1:0] pos_q;
  logic          ph_q;

  wire [CW-1:0] bs      = blk_large ? CW'(BLK_L) : CW'(BLK_S);
  wire [CW-1:0] hw      = bdr_wide ? CW'(BDR_W / 2) : CW'(BDR_N / 2);
  wire [CW-1:0] ofs_mod = CW'(grid_ofs) % bs;
  wire [CW-1:0] cur_pos = line_start ? ofs_mod : pos_q;
  wire          cur_ph  = line_start ? 1'b0 : ph_q;
  wire [CW-1:0] nxt_pos = (cur_pos >= bs - 1'b1) ? '0 : cur_pos + 1'b1;
  wire          in_bdr  = (cur_pos < hw) || (cur_pos >= bs - hw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      ph_q  <= 1'b0;
    end else if (smp_vld) begin
      ph_q  <= ~cur_ph;
      pos_q <= cur_ph ? nxt_pos : cur_pos;
    end else if (line_start) begin
      ph_q  <= 1'b0;
      pos_q <= ofs_mod;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o    <= 1'b0;
      data_o   <= '0;
      border_o <= 1'b0;
    end else begin
      vld_o    <= smp_vld;
      data_o   <= smp_data;
      border_o <= smp_vld & in_bdr;
    end
  end

endmodule

// File: rtl/pix_blk_border_chk.sv
module pix_blk_border_chk #(
  parameter int BLK_S = 8,
  parameter int BLK_L = 16,
  parameter int OFS_W = 4,
  parameter int CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic             smp_vld,
  input logic             blk_large,
  input logic [OFS_W-1:0] grid_ofs,
  input logic             vld_o,
  input logic             border_o,
  input logic [CW-1:0]    pos_q,
  input logic             ph_q
);

  wire [CW-1:0] exp_start = CW'(grid_ofs) % (blk_large ? CW'(BLK_L) : CW'(BLK_S));

  AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> !border_o); // R6

  AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> vld_o == $past(smp_vld)); // R6

  AST_PH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !line_start |=> ph_q != $past(ph_q)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld && !line_start |=> $stable(pos_q) && $stable(ph_q)); // R2

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !line_start && ph_q |=> pos_q != $past(pos_q)); // R3

  AST_START_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && !smp_vld |=> pos_q == $past(exp_start) && !ph_q); // R5

endmodule

bind pix_blk_border pix_blk_border_chk #(
  .BLK_S(BLK_S), .BLK_L(BLK_L), .OFS_W(OFS_W), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .smp_vld(smp_vld),
  .blk_large(blk_large), .grid_ofs(grid_ofs), .vld_o(vld_o),
  .border_o(border_o), .pos_q(pos_q), .ph_q(ph_q)
);

// File: tb/sim_pix_blk_border.sv
module sim_pix_blk_border;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       line_start = 0;
  logic       smp_vld = 0;
  logic [7:0] smp_data = 0;
  logic       blk_large = 0;
  logic       bdr_wide = 0;
  logic [3:0] grid_ofs = 0;
  logic       vld_o;
  logic [7:0] data_o;
  logic       border_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pix_blk_border u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .smp_vld(smp_vld),
    .smp_data(smp_data), .blk_large(blk_large), .bdr_wide(bdr_wide),
    .grid_ofs(grid_ofs), .vld_o(vld_o), .data_o(data_o), .border_o(border_o)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_border(bit b16, bit wide, int ofs, int k);
    int bs = b16 ? 16 : 8;
    int hw = wide ? 2 : 1;
    int p = ((ofs % bs) + k / 2) % bs;
    return (p < hw) || (p >= bs - hw);
  endfunction

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 vld_o in reset", vld_o, 0);
    chk("R1 border_o in reset", border_o, 0);
    chk("R1 data_o in reset", data_o, 0);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 vld_o after reset", vld_o, 0);
    chk("R1 border_o after reset", border_o, 0);
  endtask

  task automatic run_line(string req, bit b16, bit wide, int ofs, int n, int gap, bit lead_idle);
    @(negedge clk);
    blk_large = b16; bdr_wide = wide; grid_ofs = 4'(ofs);
    if (lead_idle) begin
      line_start = 1; smp_vld = 0;
      @(posedge clk);
      @(negedge clk);
      line_start = 0;
      chk({req, " R6 strobe-only vld"}, vld_o, 0);
      chk({req, " R6 strobe-only border"}, border_o, 0);
    end
    for (int k = 0; k < n; k++) begin
      line_start = (k == 0) && !lead_idle;
      smp_vld = 1;
      smp_data = 8'(k * 7 + 3);
      @(posedge clk);
      @(negedge clk);
      line_start = 0;
      smp_vld = 0;
      chk({req, " R6 vld"}, vld_o, 1);
      chk({req, " R6 data"}, data_o, (k * 7 + 3) & 255);
      chk({req, " R4 border"}, border_o, exp_border(b16, wide, ofs, k));
      if (gap > 0 && (k % gap) == gap - 1) begin
        @(posedge clk);
        @(negedge clk);
        chk({req, " R2 idle vld"}, vld_o, 0);
        chk({req, " R6 idle border"}, border_o, 0);
      end
    end
  endtask

  initial begin
    t_reset();
    run_line("R3 small narrow ofs0", 0, 0, 0, 40, 0, 0);
    run_line("R3 large wide ofs5", 1, 1, 5, 70, 0, 0);
    run_line("R5 small wide ofs13 modulo", 0, 1, 13, 37, 0, 0);
    run_line("R5 large narrow ofs15", 1, 0, 15, 45, 0, 0);
    run_line("R2 gaps small wide ofs3", 0, 1, 3, 41, 3, 0);
    run_line("R2 gaps large wide ofs9", 1, 1, 9, 50, 2, 0);
    run_line("R5 strobe then data ofs6", 0, 0, 6, 33, 0, 1);
    run_line("R5 strobe then data large ofs14", 1, 1, 14, 39, 5, 1);
    run_line("R5 restart small ofs7", 0, 1, 7, 20, 0, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule